// File: doc/BRIEF.md
# Interrupt Entry State Sequencer

This block performs, in a single clock, the processor-side state change that happens when an interruption is taken. It watches a request line that carries a 5-bit vector number and a flag that marks a high-priority machine check. It decides whether the request may be taken, using the interrupt-enable bit of the live status word. A machine check of that class is taken no matter what that bit says.

When a request is taken, the block does the following on the same clock edge:
- It saves the incoming status word into an interruption status register.
- It replaces the status word with an entry value in which only the endian bit and the machine-check bit can be set.
- It drops the privilege level to 0.
- It copies seven fixed general registers into a shadow file.
- It raises a one-cycle redirect strobe, together with the handler address. The handler address is the vector base plus a 32-byte slot per vector.

In cycles with no accepted request, the status word and privilege outputs follow their inputs one clock later. The saved status, the shadows and the redirect address keep their values.

Top module: `intr_entry_seq`

## Requirements
- R1: On an accepted request, `ipsw_o` equals the value `psw_cur_i` had at the accepting edge.
- R2: On an accepted request, `priv_o` becomes 0, whatever `priv_cur_i` was.
- R3: On an accepted request, status bit 5 (endian) of `psw_o` equals `dflt_endian_i`.
- R4: On an accepted request, status bit 4 (machine check) of `psw_o` is 1 when `hpmc_i` was 1, and 0 otherwise.
- R5: On an accepted request, every other status bit of `psw_o` is 0. This includes bit 3 (queue freeze), bit 2 (protection), bit 1 (translation) and bit 0 (interrupt enable).
- R6: On an accepted request, `shadow_o` slices 0 to 6 hold general registers 1, 8, 9, 16, 17, 24 and 25, taken from `gpr_i`. Register n is `gpr_i[32n+31:32n]`.
- R7: On an accepted request, `redirect_pc_o` equals `vbase_i + 32*vec_i`, modulo 2^32.
- R8: When `req_i` is 1 and `hpmc_i` is 0, the request is accepted only if bit 0 of `psw_cur_i` is 1.
- R9: When `req_i` and `hpmc_i` are both 1, the request is accepted even if bit 0 of `psw_cur_i` is 0.
- R10: `redirect_o` is high for exactly the cycle after each accepting edge. It is low after any edge with no acceptance.
- R11: While reset is held, every output reads 0.
- R12: After an edge with no acceptance, `psw_o` and `priv_o` equal the values that `psw_cur_i` and `priv_cur_i` had at that edge. `ipsw_o`, `shadow_o` and `redirect_pc_o` keep their values. `hpmc_i` with `req_i` low is not an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Interruption request |
| hpmc_i | input | 1 | Request is a high-priority machine check |
| vec_i | input | 5 | Vector number |
| psw_cur_i | input | 32 | Live status word |
| priv_cur_i | input | 2 | Live privilege level |
| vbase_i | input | 32 | Vector base address |
| dflt_endian_i | input | 1 | Default endian value |
| gpr_i | input | 1024 | Flat view of 32 general registers |
| psw_o | output | 32 | New status word |
| ipsw_o | output | 32 | Saved status word |
| priv_o | output | 2 | New privilege level |
| shadow_o | output | 224 | Seven shadow registers |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | 32 | Handler fetch address |

## Verification
All state in this block sits in output registers, so any wrong internal decision shows up at the ports one clock after the edge that made it. A wrong acceptance decision shows as a strobe that fires on a masked request, or stays low for a machine check. The same wrong decision also shows as a clobbered saved status word or shadow file in the following cycle.

A wrong entry status value or a wrong slot scaling shows up in `psw_o` or `redirect_pc_o` during the strobe cycle itself. Each case is compared in exactly that cycle.

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int XLEN      = 32,
  parameter int SWW       = 32,
  parameter int VECW      = 5,
  parameter int SLOT_LOG2 = 5,
  parameter int PRIVW     = 2,
  parameter int NREG      = 32,
  parameter int E_POS     = 5,
  parameter int M_POS     = 4,
  parameter int Q_POS     = 3,
  parameter int C_POS     = 2,
  parameter int D_POS     = 1,
  parameter int I_POS     = 0,
  localparam int NSHD     = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic                   hpmc_i,
  input  logic [VECW-1:0]        vec_i,
  input  logic [SWW-1:0]         psw_cur_i,
  input  logic [PRIVW-1:0]       priv_cur_i,
  input  logic [XLEN-1:0]        vbase_i,
  input  logic                   dflt_endian_i,
  input  logic [NREG*XLEN-1:0]   gpr_i,
  output logic [SWW-1:0]         psw_o,
  output logic [SWW-1:0]         ipsw_o,
  output logic [PRIVW-1:0]       priv_o,
  output logic [NSHD*XLEN-1:0]   shadow_o,
  output logic                   redirect_o,
  output logic [XLEN-1:0]        redirect_pc_o
);

  function automatic int src_idx(input int k);
    case (k)
      0:       return 1;
      1:       return 8;
      2:       return 9;
      3:       return 16;
      4:       return 17;
      5:       return 24;
      default: return 25;
    endcase
  endfunction

  logic            take;
  logic [SWW-1:0]  entry_psw;
  logic [XLEN-1:0] slot_off;
  logic            unused_gpr;

  assign take       = req_i & (hpmc_i | psw_cur_i[I_POS]);
  assign slot_off   = {{(XLEN-VECW){1'b0}}, vec_i} << SLOT_LOG2;
  assign unused_gpr = ^gpr_i;

  always_comb begin
    entry_psw        = '0;
    entry_psw[E_POS] = dflt_endian_i;
    entry_psw[M_POS] = hpmc_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw_o         <= '0;
      ipsw_o        <= '0;
      priv_o        <= '0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      redirect_o <= take;
      if (take) begin
        psw_o         <= entry_psw;
        ipsw_o        <= psw_cur_i;
        priv_o        <= '0;
        redirect_pc_o <= vbase_i + slot_off;
      end else begin
        psw_o  <= psw_cur_i;
        priv_o <= priv_cur_i;
      end
    end
  end

  for (genvar k = 0; k < NSHD; k++) begin : g_shadow
    localparam int SRC = src_idx(k);
    always_ff @(posedge clk) begin
      if (!rst_n)
        shadow_o[k*XLEN +: XLEN] <= '0;
      else if (take)
        shadow_o[k*XLEN +: XLEN] <= gpr_i[SRC*XLEN +: XLEN];
    end
  end

  AST_IPSW_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> ipsw_o == $past(psw_cur_i)); // R1

  AST_PRIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> priv_o == '0); // R2

  AST_ENDIAN: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> psw_o[E_POS] == $past(dflt_endian_i)); // R3

  AST_MCHK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> psw_o[M_POS] == $past(hpmc_i)); // R4

  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> ($countones(psw_o) <= 2 && !psw_o[Q_POS] && !psw_o[C_POS]
                    && !psw_o[D_POS] && !psw_o[I_POS])); // R5

  AST_SLOT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> redirect_pc_o == $past(vbase_i) + ({{(XLEN-VECW){1'b0}}, $past(vec_i)} << SLOT_LOG2)); // R7

  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_i) && !$past(hpmc_i) && !$past(psw_cur_i[I_POS])) |-> !redirect_o); // R8

  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_i) && $past(hpmc_i)) |-> redirect_o); // R9

  AST_HOLD_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !redirect_o) |-> ($stable(ipsw_o) && $stable(redirect_pc_o) && $stable(shadow_o))); // R12

endmodule

// File: tb/intr_entry_seq_test.sv
module intr_entry_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, req, hpmc, endian;
  logic [4:0]   vec;
  logic [31:0]  psw, base;
  logic [1:0]   priv;
  logic [1023:0] gpr;
  logic [31:0]  psw_o, ipsw_o, pc_o;
  logic [1:0]   priv_o;
  logic [223:0] shd_o;
  logic         redir;

  intr_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .hpmc_i(hpmc), .vec_i(vec),
    .psw_cur_i(psw), .priv_cur_i(priv), .vbase_i(base), .dflt_endian_i(endian),
    .gpr_i(gpr), .psw_o(psw_o), .ipsw_o(ipsw_o), .priv_o(priv_o),
    .shadow_o(shd_o), .redirect_o(redir), .redirect_pc_o(pc_o));

  typedef struct packed {
    logic        rq;
    logic        mc;
    logic        en;
    logic [4:0]  vn;
    logic [31:0] sw;
    logic [31:0] vb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 5'd3,  32'h0000_0001, 32'h0001_0000},
    '{1'b1, 1'b0, 1'b1, 5'd7,  32'hFFFF_FFFE, 32'h0002_0000},
    '{1'b1, 1'b1, 1'b1, 5'd1,  32'hFFFF_FFFE, 32'h0003_0000},
    '{1'b1, 1'b0, 1'b1, 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FC00},
    '{1'b0, 1'b1, 1'b0, 5'd9,  32'h0000_0005, 32'h0004_0000},
    '{1'b1, 1'b1, 1'b0, 5'd0,  32'h0000_0001, 32'h8000_0000},
    '{1'b1, 1'b0, 1'b0, 5'd16, 32'hA5A5_A5A5, 32'h0000_1000},
    '{1'b1, 1'b0, 1'b1, 5'd12, 32'h0000_0002, 32'h0005_0000}
  };

  int n_chk = 0, n_bad = 0;
  logic [31:0] e_ipsw = '0, e_pc = '0;
  logic [223:0] e_shd = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int src_of(input int k);
    int t [7] = '{1, 8, 9, 16, 17, 24, 25};
    return t[k];
  endfunction

  task automatic check_all_held(input string tag);
    chk({tag, " R12 ipsw held"}, ipsw_o, e_ipsw);
    chk({tag, " R12 pc held"}, pc_o, e_pc);
    for (int k = 0; k < 7; k++)
      chk({tag, " R12 shadow held"}, shd_o[k*32 +: 32], e_shd[k*32 +: 32]);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 0; hpmc = 0; endian = 0; vec = '0;
    psw = '0; base = '0; priv = '0; gpr = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset psw", psw_o, 32'h0);
    chk("R11 reset ipsw", ipsw_o, 32'h0);
    chk("R11 reset priv", {30'h0, priv_o}, 32'h0);
    chk("R11 reset redirect", {31'h0, redir}, 32'h0);
    chk("R11 reset pc", pc_o, 32'h0);
    chk("R11 reset shadow", shd_o[31:0] | shd_o[223:192], 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      logic acc;
      logic [31:0] epsw;
      req = TBL[n].rq; hpmc = TBL[n].mc; endian = TBL[n].en; vec = TBL[n].vn;
      psw = TBL[n].sw; base = TBL[n].vb; priv = 2'(n % 3 + 1);
      for (int i = 0; i < 32; i++) gpr[i*32 +: 32] = {8'(n), 8'hA5, 16'(i * 3 + 1)};
      acc = TBL[n].rq & (TBL[n].mc | TBL[n].sw[0]);
      @(negedge clk);
      chk(acc ? (TBL[n].mc ? "R9 accept" : "R8 accept") : "R8 reject",
          {31'h0, redir}, {31'h0, acc});
      if (acc) begin
        epsw = '0; epsw[5] = TBL[n].en; epsw[4] = TBL[n].mc;
        e_ipsw = TBL[n].sw;
        e_pc = TBL[n].vb + {22'h0, TBL[n].vn, 5'h0};
        for (int k = 0; k < 7; k++) e_shd[k*32 +: 32] = gpr[src_of(k)*32 +: 32];
        chk("R1 ipsw", ipsw_o, e_ipsw);
        chk("R2 priv", {30'h0, priv_o}, 32'h0);
        chk("R3 endian", {31'h0, psw_o[5]}, {31'h0, TBL[n].en});
        chk("R4 mcheck", {31'h0, psw_o[4]}, {31'h0, TBL[n].mc});
        chk("R5 psw", psw_o, epsw);
        chk("R7 pc", pc_o, e_pc);
        for (int k = 0; k < 7; k++) chk("R6 shadow", shd_o[k*32 +: 32], e_shd[k*32 +: 32]);
      end else begin
        chk("R12 psw follow", psw_o, TBL[n].sw);
        chk("R12 priv follow", {30'h0, priv_o}, {30'h0, priv});
        check_all_held("vec");
      end
      req = 0; hpmc = 0; psw = 32'h0000_00C1; priv = 2'd3;
      @(negedge clk);
      chk("R10 strobe drop", {31'h0, redir}, 32'h0);
      chk("R12 psw follow idle", psw_o, 32'h0000_00C1);
      chk("R12 priv follow idle", {30'h0, priv_o}, 32'h3);
      check_all_held("idle");
    end

    req = 1; hpmc = 0; psw = 32'h1; vec = 5'd2; base = 32'h100; endian = 0;
    @(negedge clk);
    chk("R10 back-to-back 1", {31'h0, redir}, 32'h1);
    vec = 5'd4;
    @(negedge clk);
    chk("R10 back-to-back 2", {31'h0, redir}, 32'h1);
    chk("R7 second pc", pc_o, 32'h180);
    req = 0;
    @(negedge clk);
    chk("R10 strobe low", {31'h0, redir}, 32'h0);

    rst_n = 0;
    @(negedge clk);
    chk("R11 reset again psw", psw_o, 32'h0);
    chk("R11 reset again pc", pc_o, 32'h0);
    chk("R11 reset again shadow", shd_o[63:32], 32'h0);
    chk("R11 reset again priv", {30'h0, priv_o}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule